// File: doc/BRIEF.md
# ECC Event Status Tracker

This block keeps a sticky record of error-correction events that a flash read path reports for two fetch buses, one for instructions and one for data. Each bus has a 2-bit status field. It shows whether the last event still pending was an uncorrectable double-bit error or a corrected single-bit error. A double-bit error always outranks a correction. Software reads every field through one status word. It clears the per-bus fields and the overlap counter by writing ones to them.

A shared saturating counter tallies single-bit corrections that arrive while an earlier correction is still unacknowledged. The count only advances when corrections are set up to raise an interrupt or a bus error. The counter clears itself whenever software clears either bus field. The block also holds three read-only items:

- a summary of the ECC events seen during the initialization signature check;
- the pass or fail verdict of that check;
- a sticky flag for a cache SRAM parity error on the instruction bus.

An interrupt request is raised while a bus field holds an event kind whose interrupt is enabled.

Top module: `ecc_evt_track`

## Requirements
- R1: While reset is asserted and right after it, every bit of `rd_data` reads 0 and `irq` is low.
- R2: Each bus field (`rd_data[1:0]` instruction, `rd_data[3:2]` data) uses the code 00 none, 01 double-bit error, 10 single-bit correction. A double-bit event writes 01. A single-bit event writes 10 unless the field holds 01, which it keeps. The code 11 never appears.
- R3: A write with `wr_en` high and any 1 in a bus field's bits clears that field on the next edge. An event for that bus in the same cycle wins, and the field takes the event's code.
- R4: The counter `rd_data[6:4]` adds one for each single-bit event that arrives while a correction is pending. A pending correction is a bus field holding 10 that is not cleared in this cycle. When neither field is pending and both buses report a correction together, one of the two is counted. Nothing is counted unless `en_sec_irq` or `en_sec_berr` is high.
- R5: The counter holds at 7 and never wraps.
- R6: The counter clears when a write carries any 1 in its own bits or in either bus field. Overlapping corrections in that same cycle are then counted from 0.
- R7: The summary field `rd_data[8:7]` ORs in bit 8 for `chk_sec` and bit 7 for `chk_ded`, only while `chk_busy` is high. So 01 means a double-bit error, 10 means only corrections and 11 means both. Only reset clears it, and it is not writable.
- R8: `rd_data[9]` (check failed) is 1 exactly when a double-bit error was seen during the check.
- R9: `rd_data[10]` is set by `ib_par_err` and stays set until reset.
- R10: `irq` is high while a bus field holds 10 with `en_sec_irq` set, or holds 01 with `en_ded_irq` set. It falls in the cycle after the write that clears the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ib_sec | input | 1 | Instruction bus single-bit correction pulse |
| ib_ded | input | 1 | Instruction bus double-bit error pulse |
| db_sec | input | 1 | Data bus single-bit correction pulse |
| db_ded | input | 1 | Data bus double-bit error pulse |
| ib_par_err | input | 1 | Cache SRAM parity error pulse on the instruction bus |
| chk_busy | input | 1 | Signature check in progress |
| chk_sec | input | 1 | Single-bit correction during the check |
| chk_ded | input | 1 | Double-bit error during the check |
| en_sec_irq | input | 1 | Single-bit corrections raise an interrupt |
| en_sec_berr | input | 1 | Single-bit corrections raise a bus error |
| en_ded_irq | input | 1 | Double-bit errors raise an interrupt |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_data | input | CNT_W+4 | Clear mask: [1:0] instruction field, [3:2] data field, [6:4] counter |
| rd_data | output | CNT_W+8 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the cycle where a clear and a new event hit the same field. A design that let the clear win would drop an error that software never saw. It also drives a correction into a field that holds a double-bit error; a wrong priority would hide the worse fault. Long bursts of overlapping corrections test saturation, where a wrapping counter would fall back to a small value. Clears that carry only a bus-field bit test the counter's side-effect clear, which a design missing that path would leave stale. Random mixes of enables, check windows and simultaneous two-bus corrections test the rule that counts only the second of two events.

// File: rtl/ecc_evt_track.sv
module ecc_evt_track #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ib_sec,
  input  logic             ib_ded,
  input  logic             db_sec,
  input  logic             db_ded,
  input  logic             ib_par_err,
  input  logic             chk_busy,
  input  logic             chk_sec,
  input  logic             chk_ded,
  input  logic             en_sec_irq,
  input  logic             en_sec_berr,
  input  logic             en_ded_irq,
  input  logic             wr_en,
  input  logic [CNT_W+3:0] wr_data,
  output logic [CNT_W+7:0] rd_data,
  output logic             irq
);
  localparam int CNT_LO = 4;
  localparam int CNT_HI = CNT_LO + CNT_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [1:0] ST_NONE = 2'b00;
  localparam logic [1:0] ST_DED  = 2'b01;
  localparam logic [1:0] ST_SEC  = 2'b10;

  logic [1:0]       ib_st, db_st, chk_sum;
  logic [CNT_W-1:0] cnt;
  logic             par;

  wire ib_clr  = wr_en & (|wr_data[1:0]);
  wire db_clr  = wr_en & (|wr_data[3:2]);
  wire cnt_clr = (wr_en & (|wr_data[CNT_HI:CNT_LO])) | ib_clr | db_clr;

  function automatic logic [1:0] st_next(input logic [1:0] cur, input logic clr,
                                         input logic sec, input logic ded);
    logic [1:0] base;
    base = clr ? ST_NONE : cur;
    if (ded)      st_next = ST_DED;
    else if (sec) st_next = (base == ST_DED) ? ST_DED : ST_SEC;
    else          st_next = base;
  endfunction

  wire       pend   = ((ib_st == ST_SEC) & ~ib_clr) | ((db_st == ST_SEC) & ~db_clr);
  wire       cnt_on = en_sec_irq | en_sec_berr;
  wire [1:0] n_sec  = {1'b0, ib_sec} + {1'b0, db_sec};
  wire [1:0] inc    = !cnt_on ? 2'd0 : pend ? n_sec : (n_sec == 2'd0 ? 2'd0 : n_sec - 2'd1);

  wire [CNT_W-1:0] cnt_base = cnt_clr ? '0 : cnt;
  wire [CNT_W:0]   cnt_sum  = {1'b0, cnt_base} + {{(CNT_W-1){1'b0}}, inc};
  wire [CNT_W-1:0] cnt_nxt  = (cnt_sum > {1'b0, CNT_MAX}) ? CNT_MAX : cnt_sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ib_st   <= ST_NONE;
      db_st   <= ST_NONE;
      cnt     <= '0;
      chk_sum <= 2'b00;
      par     <= 1'b0;
    end else begin
      ib_st <= st_next(ib_st, ib_clr, ib_sec, ib_ded);
      db_st <= st_next(db_st, db_clr, db_sec, db_ded);
      cnt   <= cnt_nxt;
      if (chk_busy) chk_sum <= chk_sum | {chk_sec, chk_ded};
      if (ib_par_err) par <= 1'b1;
    end
  end

  assign rd_data = {par, chk_sum[0], chk_sum, cnt, db_st, ib_st};
  assign irq = ((ib_st == ST_SEC) & en_sec_irq) | ((ib_st == ST_DED) & en_ded_irq)
             | ((db_st == ST_SEC) & en_sec_irq) | ((db_st == ST_DED) & en_ded_irq);
endmodule

module ecc_evt_track_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ib_sec,
  input logic        ib_ded,
  input logic        db_sec,
  input logic        wr_en,
  input logic [6:0]  wr_data,
  input logic        chk_busy,
  input logic        chk_ded,
  input logic        en_sec_irq,
  input logic        en_sec_berr,
  input logic        ib_par_err,
  input logic [10:0] rd_data,
  input logic        irq
);
  p_no_rsv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] != 2'b11 && rd_data[3:2] != 2'b11);
  p_ded_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ib_ded |=> rd_data[1:0] == 2'b01);
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1:0] != 2'b00 && !ib_sec && !ib_ded) |=> rd_data[1:0] == 2'b00);
  p_no_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_sec_irq && !en_sec_berr) |=> rd_data[6:4] <= $past(rd_data[6:4]));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6:4] == 3'd7 && !(wr_en && wr_data != 7'd0)) |=> rd_data[6:4] == 3'd7);
  p_clr_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3:0] != 4'd0 && !ib_sec && !db_sec) |=> rd_data[6:4] == 3'd0);
  p_sum_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_busy |=> $stable(rd_data[8:7]));
  p_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_busy && chk_ded) |=> rd_data[9]);
  p_par_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[10] || ib_par_err) |=> rd_data[10]);
  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[3:0] != 4'd0));
endmodule

bind ecc_evt_track ecc_evt_track_chk u_chk (.*);

// File: tb/ecc_evt_track_test.sv
module ecc_evt_track_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ib_sec = 0, ib_ded = 0, db_sec = 0, db_ded = 0, ib_par_err = 0;
  logic chk_busy = 0, chk_sec = 0, chk_ded = 0;
  logic en_sec_irq = 0, en_sec_berr = 0, en_ded_irq = 0;
  logic wr_en = 0;
  logic [6:0]  wr_data = '0;
  logic [10:0] rd_data;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [1:0] m_ib = 0, m_db = 0, m_sum = 0;
  int         m_cnt = 0;
  logic       m_par = 0;

  always #10 clk = ~clk;

  ecc_evt_track uut (.*);

  function automatic logic [1:0] f_next(input logic [1:0] cur, input logic clr,
                                        input logic sec, input logic ded);
    logic [1:0] b = clr ? 2'b00 : cur;
    if (ded) return 2'b01;
    if (sec) return (b == 2'b01) ? 2'b01 : 2'b10;
    return b;
  endfunction

  function automatic logic f_irq(input logic [1:0] a, input logic [1:0] b,
                                 input logic esi, input logic edi);
    return ((a == 2'b10 || b == 2'b10) && esi) || ((a == 2'b01 || b == 2'b01) && edi);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 ibus field", rd_data[1:0], m_ib);
    chk("R2 dbus field", rd_data[3:2], m_db);
    chk("R4 counter", rd_data[6:4], m_cnt);
    chk("R7 init summary", rd_data[8:7], m_sum);
    chk("R8 check failed", rd_data[9], m_sum[0]);
    chk("R9 parity flag", rd_data[10], m_par);
    chk("R10 irq", irq, f_irq(m_ib, m_db, en_sec_irq, en_ded_irq));
  endtask

  task automatic cyc(input logic is, input logic id, input logic ds, input logic dd,
                     input logic pe, input logic cb, input logic cs, input logic cd,
                     input logic esi, input logic esb, input logic edi,
                     input logic we, input logic [6:0] wd);
    logic ic, dc, cc, pend;
    int n, inc;
    ib_sec = is; ib_ded = id; db_sec = ds; db_ded = dd; ib_par_err = pe;
    chk_busy = cb; chk_sec = cs; chk_ded = cd;
    en_sec_irq = esi; en_sec_berr = esb; en_ded_irq = edi;
    wr_en = we; wr_data = wd;
    ic = we && wd[1:0] != 0;
    dc = we && wd[3:2] != 0;
    cc = (we && wd[6:4] != 0) || ic || dc;
    pend = (m_ib == 2'b10 && !ic) || (m_db == 2'b10 && !dc);
    n = int'(is) + int'(ds);
    inc = !(esi || esb) ? 0 : pend ? n : (n > 0 ? n - 1 : 0);
    m_cnt = (cc ? 0 : m_cnt) + inc;
    if (m_cnt > 7) m_cnt = 7;
    m_ib = f_next(m_ib, ic, is, id);
    m_db = f_next(m_db, dc, ds, dd);
    if (cb) m_sum = m_sum | {cs, cd};
    if (pe) m_par = 1'b1;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset rd_data", rd_data, 0);
    chk("R1 reset irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", rd_data, 0);

    // R2: correction then double-bit error, correction cannot downgrade it
    cyc(1,0,0,0, 0,0,0,0, 1,0,1, 0,7'd0);
    cyc(0,1,0,0, 0,0,0,0, 1,0,1, 0,7'd0);
    cyc(1,0,0,0, 0,0,0,0, 1,0,1, 0,7'd0);
    chk("R2 sec keeps 01", rd_data[1:0], 2'b01);
    // R3: clear and new event in the same cycle, event wins
    cyc(0,0,0,1, 0,0,0,0, 1,0,1, 0,7'd0);
    cyc(0,0,1,0, 0,0,0,0, 1,0,1, 1,7'b0001100);
    chk("R3 event beats clear", rd_data[3:2], 2'b10);
    cyc(0,0,0,0, 0,0,0,0, 1,0,1, 1,7'b0000011);
    chk("R3 plain clear", rd_data[1:0], 2'b00);
    // R4: disabled counting
    cyc(0,0,1,0, 0,0,0,0, 0,0,0, 0,7'd0);
    cyc(0,0,1,0, 0,0,0,0, 0,0,0, 0,7'd0);
    chk("R4 no count when disabled", rd_data[6:4], 0);
    // R5: saturation with bus error enable only
    for (int i = 0; i < 10; i++) cyc(0,0,1,0, 0,0,0,0, 0,1,0, 0,7'd0);
    chk("R5 saturates at 7", rd_data[6:4], 7);
    // R10: irq drops after clearing the field
    cyc(0,0,0,0, 0,0,0,0, 1,0,0, 0,7'd0);
    chk("R10 irq high on 10", irq, 1);
    cyc(0,0,0,0, 0,0,0,0, 1,0,0, 1,7'b0000100);
    chk("R10 irq low after clear", irq, 0);
    // R6: counter cleared as side effect of field clear
    chk("R6 counter cleared by field clear", rd_data[6:4], 0);
    // R7/R8: summary only while busy
    cyc(0,0,0,0, 0,0,1,1, 0,0,0, 0,7'd0);
    chk("R7 ignored when idle", rd_data[8:7], 0);
    cyc(0,0,0,0, 0,1,1,0, 0,0,0, 0,7'd0);
    chk("R8 pass on corrections only", rd_data[9], 0);
    cyc(0,0,0,0, 0,1,0,1, 0,0,0, 1,7'h7f);
    chk("R7 both kinds", rd_data[8:7], 2'b11);
    // R9
    cyc(0,0,0,0, 1,0,0,0, 0,0,0, 1,7'h7f);
    cyc(0,0,0,0, 0,0,0,0, 0,0,0, 1,7'h7f);
    chk("R9 parity sticky", rd_data[10], 1);

    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 4) == 0, ($urandom % 12) == 0, ($urandom % 4) == 0, ($urandom % 12) == 0,
          ($urandom % 200) == 0, ($urandom % 64) == 0 ? 1'b1 : chk_busy ^ (($urandom % 50) == 0),
          ($urandom % 6) == 0, ($urandom % 40) == 0,
          $urandom % 2, $urandom % 2, $urandom % 2,
          ($urandom % 6) == 0, 7'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule